// File: doc/BRIEF.md
# Counter-Machine Program Interpreter

This block is a small sequential engine. It runs a fixed register-machine program over three unsigned count registers, called A, B and C (register numbers 1, 2 and 3). Each program step names one of three operations, a register, a next step and, for the conditional operation, an alternate step. The engine takes one step per clock. Each step updates the chosen register and selects the following step. The run stops when the engine reaches a stop step.

A start pulse copies the three initial values into the registers and points the engine at step 1. When the stop step executes, the done flag rises. The final register values can then be read on the outputs, where they stay frozen until the next start. The program is built into an internal table at elaboration, chosen by a parameter. Program 0 drains register B into register C. Program 1 copies register A into register C and uses register B as a scratch holding area.

Top module: `cm_interp`

## Requirements
- R1: After reset, done is 0 and all three result outputs are 0.
- R2: A start pulse sampled at a clock edge loads the three initial values, sets the step pointer to step 1 and clears done. This applies even while a run is in progress. The loaded values appear on the outputs immediately after that edge.
- R3: A decrement-or-branch step on a nonzero register lowers it by one and continues at the step's next-step field.
- R4: A decrement-or-branch step on a zero register leaves it unchanged and continues at the step's alternate-step field.
- R5: An increment step adds one to its register and continues at the next-step field. A register that already holds the maximum (255 for 8 bits) keeps that value.
- R6: A stop step raises done. Done then stays high, and all results hold their values, until the next start pulse. Changes on the initial-value inputs have no effect meanwhile.
- R7: Exactly one step executes per clock. Done is seen K edges after the start edge, where K is the number of steps executed, counting the stop step.
- R8: Program 0 ends with A unchanged, B equal to 0 and C equal to min(C+B, 255). It takes 2B+2 steps.
- R9: Program 1 ends with B equal to 0, C equal to min(C+A, 255) and A equal to min(A+B, 255). It takes 3A+2·min(A+B,255)+3 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load initial values and begin at step 1 |
| init_a | input | W | Initial value of register 1 |
| init_b | input | W | Initial value of register 2 |
| init_c | input | W | Initial value of register 3 |
| done | output | 1 | High once the stop step has executed |
| out_a | output | W | Current value of register 1 |
| out_b | output | W | Current value of register 2 |
| out_c | output | W | Current value of register 3 |

## Verification
Saturation is the hardest case to reach. An increment only meets a full register after a long run of loop passes, so the stimulus starts register C close to 255 and lets the drain loop push it past the top. For program 1, A and B are chosen so that their sum overflows. A restart in the middle of a long run is also exercised, by starting a run of about 400 steps and pulsing start again after ten edges. Zero initial values drive the alternate-step path right at step 1.

// File: rtl/cm_pkg.sv
package cm_pkg;

    localparam int CM_NREG   = 3;
    localparam int CM_SEL_W  = 2;
    localparam int CM_STEP_W = 4;   // steps 1..15 addressable

    typedef enum logic [1:0] {
        OP_STOP = 2'd0,
        OP_INC  = 2'd1,
        OP_DEB  = 2'd2
    } cm_op_e;

    typedef struct packed {
        cm_op_e                 op;
        logic [CM_SEL_W-1:0]    rsel;   // 1-based register number
        logic [CM_STEP_W-1:0]   go;     // next step
        logic [CM_STEP_W-1:0]   alt;    // step taken when register is zero
    } cm_step_t;

    function automatic cm_step_t mk(cm_op_e op, int unsigned r, int unsigned g, int unsigned a);
        cm_step_t s;
        s.op   = op;
        s.rsel = CM_SEL_W'(r);
        s.go   = CM_STEP_W'(g);
        s.alt  = CM_STEP_W'(a);
        return s;
    endfunction

    // Built-in programs; any unlisted step is a stop step.
    function automatic cm_step_t prog_step(int unsigned prog, int unsigned idx);
        cm_step_t s;
        s = mk(OP_STOP, 0, 0, 0);
        if (prog == 0) begin
            // drain B into C
            case (idx)
                1: s = mk(OP_DEB, 2, 2, 3);
                2: s = mk(OP_INC, 3, 1, 0);
                default: s = mk(OP_STOP, 0, 0, 0);
            endcase
        end else begin
            // copy A into C through B
            case (idx)
                1: s = mk(OP_DEB, 1, 2, 4);
                2: s = mk(OP_INC, 2, 3, 0);
                3: s = mk(OP_INC, 3, 1, 0);
                4: s = mk(OP_DEB, 2, 5, 6);
                5: s = mk(OP_INC, 1, 4, 0);
                default: s = mk(OP_STOP, 0, 0, 0);
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/cm_prog_rom.sv
module cm_prog_rom
    import cm_pkg::*;
#(
    parameter int PROGRAM = 0,
    parameter int DEPTH   = 8
) (
    input  logic [CM_STEP_W-1:0] pc_i,
    output cm_step_t             step_o
);

    cm_step_t table_w [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tab
        assign table_w[k] = prog_step(PROGRAM, k + 1);
    end

    always_comb begin
        step_o = mk(OP_STOP, 0, 0, 0);
        for (int k = 0; k < DEPTH; k++) begin
            if (pc_i == CM_STEP_W'(k + 1)) step_o = table_w[k];
        end
    end

endmodule

// File: rtl/cm_reg_file.sv
module cm_reg_file
    import cm_pkg::*;
#(
    parameter int W    = 8,
    parameter int NREG = CM_NREG
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [NREG-1:0][W-1:0]       init_vals,
    input  logic                         do_inc,
    input  logic                         do_dec,
    input  logic [CM_SEL_W-1:0]          sel,
    output logic [NREG-1:0][W-1:0]       vals,
    output logic                         sel_zero
);

    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        logic [NREG-1:0][W-1:0] val;
    } rf_s;

    rf_s rf_d, rf_q;

    always_comb begin
        rf_d     = rf_q;
        sel_zero = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (sel == CM_SEL_W'(i + 1)) begin
                sel_zero = (rf_q.val[i] == '0);
                if (do_inc && rf_q.val[i] != MAXV) rf_d.val[i] = rf_q.val[i] + 1'b1;
                if (do_dec && rf_q.val[i] != '0)   rf_d.val[i] = rf_q.val[i] - 1'b1;
            end
        end
        if (load) rf_d.val = init_vals;
    end

    always_ff @(posedge clk) begin
        if (rst) rf_q <= '0;
        else     rf_q <= rf_d;
    end

    assign vals = rf_q.val;

    p_no_dec_zero_r4: assert property (@(posedge clk) disable iff (rst)
        do_dec |-> !sel_zero);

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
            (!load && do_inc && sel == CM_SEL_W'(g + 1) && rf_q.val[g] == MAXV)
            |=> rf_q.val[g] == MAXV);
        p_inc_r5: assert property (@(posedge clk) disable iff (rst)
            (!load && do_inc && sel == CM_SEL_W'(g + 1) && rf_q.val[g] != MAXV)
            |=> rf_q.val[g] == W'($past(rf_q.val[g]) + 1'b1));
        p_dec_r3: assert property (@(posedge clk) disable iff (rst)
            (!load && do_dec && sel == CM_SEL_W'(g + 1))
            |=> rf_q.val[g] == W'($past(rf_q.val[g]) - 1'b1));
    end

endmodule

// File: rtl/cm_seq.sv
module cm_seq
    import cm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  cm_step_t             step,
    input  logic                 sel_zero,
    output logic [CM_STEP_W-1:0] pc,
    output logic                 done,
    output logic                 load,
    output logic                 do_inc,
    output logic                 do_dec,
    output logic [CM_SEL_W-1:0]  sel
);

    typedef struct packed {
        logic [CM_STEP_W-1:0] pc;
        logic                 busy;
        logic                 done;
    } seq_s;

    seq_s sq_d, sq_q;
    logic exec;

    always_comb begin
        sq_d = sq_q;
        exec = sq_q.busy && !start;
        if (start) begin
            sq_d.pc   = CM_STEP_W'(1);
            sq_d.busy = 1'b1;
            sq_d.done = 1'b0;
        end else if (sq_q.busy) begin
            case (step.op)
                OP_INC:  sq_d.pc = step.go;
                OP_DEB:  sq_d.pc = sel_zero ? step.alt : step.go;
                default: begin
                    sq_d.busy = 1'b0;
                    sq_d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sq_q <= '{pc: CM_STEP_W'(1), busy: 1'b0, done: 1'b0};
        else     sq_q <= sq_d;
    end

    assign pc     = sq_q.pc;
    assign done   = sq_q.done;
    assign load   = start;
    assign sel    = step.rsel;
    assign do_inc = exec && step.op == OP_INC;
    assign do_dec = exec && step.op == OP_DEB && !sel_zero;

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (sq_q.pc == CM_STEP_W'(1) && !sq_q.done && sq_q.busy));
    p_go_r3: assert property (@(posedge clk) disable iff (rst)
        (exec && step.op == OP_DEB && !sel_zero) |=> sq_q.pc == $past(step.go));
    p_alt_r4: assert property (@(posedge clk) disable iff (rst)
        (exec && step.op == OP_DEB && sel_zero) |=> sq_q.pc == $past(step.alt));
    p_inc_go_r5: assert property (@(posedge clk) disable iff (rst)
        (exec && step.op == OP_INC) |=> sq_q.pc == $past(step.go));
    p_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (exec && step.op == OP_STOP) |=> sq_q.done);
    p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (sq_q.done && !start) |=> sq_q.done);
    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(sq_q.done && sq_q.busy));

endmodule

// File: rtl/cm_interp.sv
module cm_interp
    import cm_pkg::*;
#(
    parameter int PROGRAM = 0,
    parameter int DEPTH   = 8,
    parameter int W       = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] init_a,
    input  logic [W-1:0] init_b,
    input  logic [W-1:0] init_c,
    output logic         done,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b,
    output logic [W-1:0] out_c
);

    logic [CM_STEP_W-1:0]          pc;
    cm_step_t                      step;
    logic                          sel_zero, load, do_inc, do_dec;
    logic [CM_SEL_W-1:0]           sel;
    logic [CM_NREG-1:0][W-1:0]     init_vals, vals;

    assign init_vals = {init_c, init_b, init_a};

    cm_prog_rom #(.PROGRAM(PROGRAM), .DEPTH(DEPTH)) rom_i (
        .pc_i   (pc),
        .step_o (step)
    );

    cm_seq seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .step     (step),
        .sel_zero (sel_zero),
        .pc       (pc),
        .done     (done),
        .load     (load),
        .do_inc   (do_inc),
        .do_dec   (do_dec),
        .sel      (sel)
    );

    cm_reg_file #(.W(W), .NREG(CM_NREG)) rf_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .init_vals (init_vals),
        .do_inc    (do_inc),
        .do_dec    (do_dec),
        .sel       (sel),
        .vals      (vals),
        .sel_zero  (sel_zero)
    );

    assign out_a = vals[0];
    assign out_b = vals[1];
    assign out_c = vals[2];

    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(out_a) && $stable(out_b) && $stable(out_c)));

endmodule

// File: tb/cm_interp_tb.sv
`timescale 1ns/1ps
module cm_interp_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_mv = 1'b0, start_cp = 1'b0;
    logic [7:0] ia = '0, ib = '0, ic = '0;
    logic done_mv, done_cp;
    logic [7:0] ma, mb, mc, ca, cb, cc;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    cm_interp #(.PROGRAM(0)) dut_i (
        .clk(clk), .rst(rst), .start(start_mv),
        .init_a(ia), .init_b(ib), .init_c(ic),
        .done(done_mv), .out_a(ma), .out_b(mb), .out_c(mc));

    cm_interp #(.PROGRAM(1)) dut_copy_i (
        .clk(clk), .rst(rst), .start(start_cp),
        .init_a(ia), .init_b(ib), .init_c(ic),
        .done(done_cp), .out_a(ca), .out_b(cb), .out_c(cc));

    function automatic int sat(int x);
        return (x > 255) ? 255 : x;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1 done_mv", int'(done_mv), 0);
        chk("R1 done_cp", int'(done_cp), 0);
        chk("R1 results", int'(ma) + int'(mb) + int'(mc) + int'(ca) + int'(cb) + int'(cc), 0);
    endtask

    // program 0: drain B into C
    task automatic run_move(input int a, input int b, input int c);
        int n;
        @(negedge clk);
        ia = 8'(a); ib = 8'(b); ic = 8'(c); start_mv = 1'b1;
        @(negedge clk);
        start_mv = 1'b0;
        chk("R2 load a", int'(ma), a);
        chk("R2 load b", int'(mb), b);
        chk("R2 load c", int'(mc), c);
        chk("R2 done cleared", int'(done_mv), 0);
        n = 0;
        @(negedge clk); n++;
        if (b > 0) chk("R3 first dec", int'(mb), b - 1);
        else begin
            chk("R4 zero kept", int'(mb), 0);
            chk("R4 not done after alt", int'(done_mv), 0);
        end
        while (!done_mv && n < 2000) begin
            @(negedge clk); n++;
        end
        chk("R7 move steps", n, 2 * b + 2);
        chk("R8 move a", int'(ma), a);
        chk("R8 move b", int'(mb), 0);
        chk("R8 move c", int'(mc), sat(c + b));
    endtask

    // program 1: copy A into C via B
    task automatic run_copy(input int a, input int b, input int c);
        int n, bm;
        bm = sat(a + b);
        @(negedge clk);
        ia = 8'(a); ib = 8'(b); ic = 8'(c); start_cp = 1'b1;
        @(negedge clk);
        start_cp = 1'b0;
        chk("R2 copy load a", int'(ca), a);
        n = 0;
        while (!done_cp && n < 3000) begin
            @(negedge clk); n++;
        end
        chk("R7 copy steps", n, 3 * a + 2 * bm + 3);
        chk("R9 copy a", int'(ca), bm);
        chk("R9 copy b", int'(cb), 0);
        chk("R9 copy c", int'(cc), sat(c + a));
    endtask

    task automatic t_hold();
        int a0, b0, c0;
        a0 = int'(ma); b0 = int'(mb); c0 = int'(mc);
        @(negedge clk);
        ia = 8'd99; ib = 8'd77; ic = 8'd55;
        repeat (6) @(negedge clk);
        chk("R6 done held", int'(done_mv), 1);
        chk("R6 a frozen", int'(ma), a0);
        chk("R6 b frozen", int'(mb), b0);
        chk("R6 c frozen", int'(mc), c0);
    endtask

    task automatic t_restart();
        @(negedge clk);
        ia = 8'd1; ib = 8'd200; ic = 8'd0; start_mv = 1'b1;
        @(negedge clk);
        start_mv = 1'b0;
        repeat (10) @(negedge clk);
        chk("R2 midrun busy", int'(done_mv), 0);
        run_move(4, 2, 5);   // restart before completion
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_move(0, 0, 0);
        run_move(3, 4, 1);
        t_hold();
        run_move(7, 10, 250);     // C saturates (R5)
        t_restart();
        run_copy(0, 0, 0);
        run_copy(3, 0, 2);
        run_copy(200, 100, 100);  // A and C saturate (R5)
        run_copy(5, 2, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule